// File: doc/BRIEF.md
# Shared Buffer Admission Controller

This block decides, one packet at a time, whether an arriving packet may take space in a switch's shared buffer. Each request names the ingress port, the packet priority (which picks the ingress priority group), the egress port, the egress traffic class and the packet length in cells. The block holds four families of occupancy counters: per ingress port, per ingress port and priority group, per egress port, and per egress port and traffic class. Each counter has a programmable maximum threshold and a programmable minimum guarantee.

A packet is admitted when the four counters it addresses all sit strictly below their maxima, or when any one of them sits strictly below its minimum guarantee. One non-zero guarantee therefore lets traffic through even where another scope has zero quotas, as happens with a CPU-bound class that has both quotas at zero. Because of this, such a class needs its own minimum guarantee so that trapped traffic is admitted whatever priority group it came from. On admit, the packet's cells are charged to all four counters. A release interface returns cells when a packet leaves.

Top module: `sba_top`

## Requirements
- R1: After reset, dec_valid_o and dec_admit_o are 0, and all counters, maxima and minima are 0, so every request is dropped until a threshold is written.
- R2: A request sampled on req_valid_i at a rising edge produces dec_valid_o = 1 for exactly the following cycle. dec_admit_o is 1 only while dec_valid_o is 1.
- R3: The priority group equals the 3-bit priority value (0..7). Class-scope entries are indexed port*8 + class. Port-scope entries are indexed by port number. Counters of different ports and different classes are independent.
- R4: A request is admitted when the four addressed usages are each strictly less than their maximum. A usage equal to its maximum fails this test.
- R5: A request is admitted when any one of the four addressed usages is strictly less than its minimum, even if other scopes fail their maximum.
- R6: A request that meets neither R4 nor R5 is dropped and leaves every counter unchanged.
- R7: On admit, the packet length is added to all four addressed counters at the decision edge, so the next request already sees the new usage.
- R8: A release pulse subtracts its length from its four addressed counters. A counter never goes below 0.
- R9: When an admit and a release address the same counter in one cycle, both are applied as one net update.
- R10: A configuration write (cfg_we_i) sets the maximum and minimum of one entry. cfg_scope_i selects the scope: 0 = ingress port, 1 = ingress port+group, 2 = egress port, 3 = egress port+class. The write applies to requests from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| cfg_we_i | input | 1 | threshold write strobe |
| cfg_scope_i | input | 2 | scope selector for the write |
| cfg_idx_i | input | PORT_W+3 | entry index within the scope |
| cfg_max_i | input | CNT_W | maximum threshold in cells |
| cfg_min_i | input | CNT_W | minimum guarantee in cells |
| req_valid_i | input | 1 | admission request strobe |
| req_in_port_i | input | PORT_W | ingress port |
| req_prio_i | input | 3 | priority, selects priority group |
| req_out_port_i | input | PORT_W | egress port |
| req_tc_i | input | 3 | egress traffic class |
| req_len_i | input | LEN_W | packet length in cells |
| rel_valid_i | input | 1 | release strobe |
| rel_in_port_i | input | PORT_W | ingress port of released packet |
| rel_prio_i | input | 3 | priority group of released packet |
| rel_out_port_i | input | PORT_W | egress port of released packet |
| rel_tc_i | input | 3 | traffic class of released packet |
| rel_len_i | input | LEN_W | cells returned |
| dec_valid_o | output | 1 | decision strobe |
| dec_admit_o | output | 1 | 1 = admitted, 0 = dropped |

## Verification
The main function is tried with requests that fill a priority group to exactly its maximum, which shows that the comparison is strict. Requests aimed at a zero-quota class are sent once with no guarantee anywhere and once with a guarantee on the ingress group or on the class itself, which separates the all-below-maximum path from the any-below-minimum path. Releases that drain a group show that the counters are charged and returned. A release on an empty counter shows that the counter saturates at zero rather than wrapping. A request and a release on the same counter in one cycle, followed by two one-cell probes against a tightened maximum, show whether either update was lost.

// File: rtl/sba_pkg.sv
package sba_pkg;
  localparam int CLS_NUM = 8;
  localparam int CLS_W   = 3;
  localparam int SCOPES  = 4;

  typedef enum logic [1:0] {
    SC_IN_PORT  = 2'd0,
    SC_IN_PG    = 2'd1,
    SC_OUT_PORT = 2'd2,
    SC_OUT_TC   = 2'd3
  } scope_e;
endpackage

// File: rtl/sba_scope.sv
// One family of occupancy counters with its max/min thresholds.
module sba_scope #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 5,
  parameter int CNT_W   = 12,
  parameter int LEN_W   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [CNT_W-1:0] cfg_max_i,
  input  logic [CNT_W-1:0] cfg_min_i,
  input  logic [IDX_W-1:0] chk_idx_i,
  input  logic             add_en_i,
  input  logic [LEN_W-1:0] add_len_i,
  input  logic             sub_en_i,
  input  logic [IDX_W-1:0] sub_idx_i,
  input  logic [LEN_W-1:0] sub_len_i,
  output logic             below_max_o,
  output logic             below_min_o
);
  localparam int WIDE_W = CNT_W + 1;

  logic [CNT_W-1:0] usage_w [ENTRIES];
  logic [CNT_W-1:0] max_w   [ENTRIES];
  logic [CNT_W-1:0] min_w   [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic             add_hit, sub_hit, cfg_hit;
    logic [CNT_W-1:0] cnt_q, max_q, min_q, cnt_d;
    logic [WIDE_W-1:0] up_w, sub_amt_w, dn_w;

    assign add_hit   = add_en_i && (chk_idx_i == IDX_W'(e));
    assign sub_hit   = sub_en_i && (sub_idx_i == IDX_W'(e));
    assign cfg_hit   = cfg_we_i && (cfg_idx_i == IDX_W'(e));
    assign up_w      = {1'b0, cnt_q} + (add_hit ? WIDE_W'(add_len_i) : '0);
    assign sub_amt_w = sub_hit ? WIDE_W'(sub_len_i) : '0;
    assign dn_w      = up_w - sub_amt_w;

    // net update: floor at zero, clamp at full scale
    always_comb begin
      if (up_w < sub_amt_w)   cnt_d = '0;
      else if (dn_w[CNT_W])   cnt_d = '1;
      else                    cnt_d = dn_w[CNT_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        max_q <= '0;
        min_q <= '0;
      end else begin
        if (add_hit || sub_hit) cnt_q <= cnt_d;
        if (cfg_hit) begin
          max_q <= cfg_max_i;
          min_q <= cfg_min_i;
        end
      end
    end

    assign usage_w[e] = cnt_q;
    assign max_w[e]   = max_q;
    assign min_w[e]   = min_q;
  end

  always_comb begin
    below_max_o = 1'b0;
    below_min_o = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (chk_idx_i == IDX_W'(e)) begin
        below_max_o = usage_w[e] < max_w[e];
        below_min_o = usage_w[e] < min_w[e];
      end
    end
  end
endmodule

// File: rtl/sba_decide.sv
// Admission rule: all scopes under max, or any scope under its guarantee.
module sba_decide #(
  parameter int N = 4
) (
  input  logic [N-1:0] below_max_i,
  input  logic [N-1:0] below_min_i,
  output logic         admit_o
);
  logic all_max, any_min;
  always_comb begin
    all_max = 1'b1;
    any_min = 1'b0;
    for (int s = 0; s < N; s++) begin
      all_max = all_max & below_max_i[s];
      any_min = any_min | below_min_i[s];
    end
  end
  assign admit_o = all_max | any_min;
endmodule

// File: rtl/sba_top.sv
module sba_top
  import sba_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int CNT_W     = 12,
  parameter int LEN_W     = 6,
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int IDX_W    = PORT_W + CLS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_scope_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [CNT_W-1:0]  cfg_max_i,
  input  logic [CNT_W-1:0]  cfg_min_i,
  input  logic              req_valid_i,
  input  logic [PORT_W-1:0] req_in_port_i,
  input  logic [CLS_W-1:0]  req_prio_i,
  input  logic [PORT_W-1:0] req_out_port_i,
  input  logic [CLS_W-1:0]  req_tc_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              rel_valid_i,
  input  logic [PORT_W-1:0] rel_in_port_i,
  input  logic [CLS_W-1:0]  rel_prio_i,
  input  logic [PORT_W-1:0] rel_out_port_i,
  input  logic [CLS_W-1:0]  rel_tc_i,
  input  logic [LEN_W-1:0]  rel_len_i,
  output logic              dec_valid_o,
  output logic              dec_admit_o
);
  logic [IDX_W-1:0]  chk_idx_w [SCOPES];
  logic [IDX_W-1:0]  rel_idx_w [SCOPES];
  logic [SCOPES-1:0] scope_below_max, scope_below_min;
  logic              admit_c, add_en;
  logic              dec_valid_q, dec_admit_q;

  // priority value selects the group directly
  assign chk_idx_w[SC_IN_PORT]  = IDX_W'(req_in_port_i);
  assign chk_idx_w[SC_IN_PG]    = {req_in_port_i, req_prio_i};
  assign chk_idx_w[SC_OUT_PORT] = IDX_W'(req_out_port_i);
  assign chk_idx_w[SC_OUT_TC]   = {req_out_port_i, req_tc_i};
  assign rel_idx_w[SC_IN_PORT]  = IDX_W'(rel_in_port_i);
  assign rel_idx_w[SC_IN_PG]    = {rel_in_port_i, rel_prio_i};
  assign rel_idx_w[SC_OUT_PORT] = IDX_W'(rel_out_port_i);
  assign rel_idx_w[SC_OUT_TC]   = {rel_out_port_i, rel_tc_i};

  assign add_en = req_valid_i & admit_c;

  for (genvar s = 0; s < SCOPES; s++) begin : g_scope
    localparam bit IS_PORT = (s == int'(SC_IN_PORT)) || (s == int'(SC_OUT_PORT));
    localparam int ENT     = IS_PORT ? NUM_PORTS : NUM_PORTS * CLS_NUM;
    logic cfg_we_s;
    assign cfg_we_s = cfg_we_i && (cfg_scope_i == 2'(s));

    sba_scope #(
      .ENTRIES(ENT),
      .IDX_W  (IDX_W),
      .CNT_W  (CNT_W),
      .LEN_W  (LEN_W)
    ) u_scope (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we_s),
      .cfg_idx_i  (cfg_idx_i),
      .cfg_max_i  (cfg_max_i),
      .cfg_min_i  (cfg_min_i),
      .chk_idx_i  (chk_idx_w[s]),
      .add_en_i   (add_en),
      .add_len_i  (req_len_i),
      .sub_en_i   (rel_valid_i),
      .sub_idx_i  (rel_idx_w[s]),
      .sub_len_i  (rel_len_i),
      .below_max_o(scope_below_max[s]),
      .below_min_o(scope_below_min[s])
    );
  end

  sba_decide #(.N(SCOPES)) u_decide (
    .below_max_i(scope_below_max),
    .below_min_i(scope_below_min),
    .admit_o    (admit_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_q <= 1'b0;
      dec_admit_q <= 1'b0;
    end else begin
      dec_valid_q <= req_valid_i;
      dec_admit_q <= add_en;
    end
  end

  assign dec_valid_o = dec_valid_q;
  assign dec_admit_o = dec_admit_q;
endmodule

// File: rtl/sba_checker.sv
module sba_checker #(
  parameter int N = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         req_valid_i,
  input logic         dec_valid_o,
  input logic         dec_admit_o,
  input logic [N-1:0] below_max_i,
  input logic [N-1:0] below_min_i
);
  a_r2_dec_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> dec_valid_o);
  a_r2_no_spurious_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !dec_valid_o);
  a_r2_admit_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_admit_o |-> dec_valid_o);
  a_r4_all_under_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (&below_max_i)) |=> dec_admit_o);
  a_r5_any_under_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (|below_min_i)) |=> dec_admit_o);
  a_r6_drop_otherwise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !(&below_max_i) && !(|below_min_i)) |=> !dec_admit_o);
endmodule

bind sba_top sba_checker #(.N(sba_pkg::SCOPES)) u_sba_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .dec_valid_o(dec_valid_o),
  .dec_admit_o(dec_admit_o),
  .below_max_i(scope_below_max),
  .below_min_i(scope_below_min)
);

// File: tb/sba_top_tb_top.sv
`timescale 1ns/1ps
module sba_top_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic       cfg_we = 0;
  logic [1:0] cfg_scope = 0;
  logic [4:0] cfg_idx = 0;
  logic [11:0] cfg_max = 0, cfg_min = 0;
  logic       req_valid = 0;
  logic [1:0] req_ip = 0, req_ep = 0;
  logic [2:0] req_pr = 0, req_tc = 0;
  logic [5:0] req_len = 0;
  logic       rel_valid = 0;
  logic [1:0] rel_ip = 0, rel_ep = 0;
  logic [2:0] rel_pr = 0, rel_tc = 0;
  logic [5:0] rel_len = 0;
  logic       dec_valid, dec_admit;

  int n_chk = 0;
  int n_bad = 0;

  sba_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_scope_i(cfg_scope), .cfg_idx_i(cfg_idx),
    .cfg_max_i(cfg_max), .cfg_min_i(cfg_min),
    .req_valid_i(req_valid), .req_in_port_i(req_ip), .req_prio_i(req_pr),
    .req_out_port_i(req_ep), .req_tc_i(req_tc), .req_len_i(req_len),
    .rel_valid_i(rel_valid), .rel_in_port_i(rel_ip), .rel_prio_i(rel_pr),
    .rel_out_port_i(rel_ep), .rel_tc_i(rel_tc), .rel_len_i(rel_len),
    .dec_valid_o(dec_valid), .dec_admit_o(dec_admit)
  );

  typedef struct packed {
    logic [1:0] ip;
    logic [2:0] pr;
    logic [1:0] ep;
    logic [2:0] tc;
    logic [5:0] len;
    logic       exp;
    logic [3:0] rq;
  } vec_t;

  // after base config: port max 100, group/class max 50, class 7 max 0, all min 0
  localparam vec_t TBL [6] = '{
    '{2'd0, 3'd1, 2'd1, 3'd1, 6'd10, 1'b1, 4'd4},  // R4 empty scopes
    '{2'd0, 3'd1, 2'd1, 3'd7, 6'd5,  1'b0, 4'd6},  // R6 zero-quota class
    '{2'd0, 3'd1, 2'd1, 3'd1, 6'd45, 1'b1, 4'd7},  // R7 group now 10
    '{2'd0, 3'd1, 2'd2, 3'd2, 6'd1,  1'b0, 4'd4},  // R4 group 55 not < 50
    '{2'd1, 3'd2, 2'd1, 3'd3, 6'd5,  1'b1, 4'd3},  // R3 other port independent
    '{2'd2, 3'd3, 2'd2, 3'd7, 6'd3,  1'b0, 4'd6}   // R6
  };

  task automatic check(input string rq, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cfg_wr(input int sc, input int idx, input int mx, input int mn);
    @(negedge clk);
    cfg_we = 1; cfg_scope = 2'(sc); cfg_idx = 5'(idx);
    cfg_max = 12'(mx); cfg_min = 12'(mn);
    @(negedge clk);
    cfg_we = 0;
  endtask

  // optional same-cycle release on identical indices
  task automatic req(input int ip, input int pr, input int ep, input int tc,
                     input int len, input bit with_rel, input int rlen,
                     input int exp, input string rq);
    @(negedge clk);
    req_valid = 1; req_ip = 2'(ip); req_pr = 3'(pr); req_ep = 2'(ep);
    req_tc = 3'(tc); req_len = 6'(len);
    if (with_rel) begin
      rel_valid = 1; rel_ip = 2'(ip); rel_pr = 3'(pr); rel_ep = 2'(ep);
      rel_tc = 3'(tc); rel_len = 6'(rlen);
    end
    @(negedge clk);
    req_valid = 0; rel_valid = 0;
    check({rq, " valid"}, int'(dec_valid), 1);
    check({rq, " admit"}, int'(dec_admit), exp);
  endtask

  task automatic rel(input int ip, input int pr, input int ep, input int tc, input int len);
    @(negedge clk);
    rel_valid = 1; rel_ip = 2'(ip); rel_pr = 3'(pr); rel_ep = 2'(ep);
    rel_tc = 3'(tc); rel_len = 6'(len);
    @(negedge clk);
    rel_valid = 0;
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(dec_valid), 0);
    check("R1 reset admit", int'(dec_admit), 0);
    rst_ni = 1;
    // R1 zero thresholds drop everything
    req(0, 0, 0, 0, 1, 0, 0, 0, "R1");

    for (int p = 0; p < 4; p++) begin
      cfg_wr(0, p, 100, 0);
      cfg_wr(2, p, 100, 0);
      for (int c = 0; c < 8; c++) begin
        cfg_wr(1, p * 8 + c, 50, 0);
        cfg_wr(3, p * 8 + c, (c == 7) ? 0 : 50, 0);
      end
    end

    for (int i = 0; i < 6; i++) begin
      req(TBL[i].ip, TBL[i].pr, TBL[i].ep, TBL[i].tc, TBL[i].len, 0, 0,
          TBL[i].exp, $sformatf("R%0d vec%0d", TBL[i].rq, i));
    end

    // R2 decision is a single-cycle pulse
    @(negedge clk);
    check("R2 pulse ends", int'(dec_valid), 0);

    // R5/R10 guarantee on ingress group 0 overrides zero class quota
    cfg_wr(1, 0, 50, 20);
    req(0, 0, 1, 7, 8, 0, 0, 1, "R5 group-0 min");
    // R6 group 1 has no guarantee
    req(0, 1, 1, 7, 2, 0, 0, 0, "R6 no guarantee");
    // R5 guarantee on the CPU class itself (port 1, class 7 -> idx 15)
    cfg_wr(3, 15, 0, 40);
    req(0, 1, 1, 7, 4, 0, 0, 1, "R5 class min");

    // R8 release drains group 1 from 59 to 4
    rel(0, 1, 1, 1, 55);
    req(0, 1, 2, 2, 1, 0, 0, 1, "R8 after release");
    // R8 release on empty counters must not wrap
    rel(2, 0, 3, 0, 10);
    req(2, 0, 3, 0, 1, 0, 0, 1, "R8 no underflow");

    // R6 drop leaves counters alone; R4 strict compare (port 3 group 6 -> idx 30)
    cfg_wr(1, 30, 5, 0);
    req(3, 6, 3, 6, 4, 0, 0, 1, "R4 fill to 4");
    req(3, 6, 3, 7, 9, 0, 0, 0, "R6 drop");
    req(3, 6, 3, 6, 1, 0, 0, 1, "R6 counter unchanged");
    req(3, 6, 3, 6, 1, 0, 0, 0, "R4 equal to max");

    // R9 same-cycle admit and release: 30 + 15 - 30 = 15
    req(3, 5, 0, 4, 30, 0, 0, 1, "R9 setup");
    req(3, 5, 0, 4, 15, 1, 30, 1, "R9 joint cycle");
    cfg_wr(1, 29, 16, 0);
    req(3, 5, 0, 4, 1, 0, 0, 1, "R9 probe 15<16");
    req(3, 5, 0, 4, 1, 0, 0, 0, "R9 probe 16<16");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule